// File: doc/BRIEF.md
# Weighted Round-Robin Slave-Side Arbiter

This block sits between a set of bus masters and a set of slaves and decides, every cycle, which master each slave serves. Every slave owns an arbiter of its own, so masters aimed at different slaves are served in the same cycle instead of queuing behind one shared bus. Each master presents a valid bit and the index of the slave it wants to read. A grant means a single-cycle read: the access completes in the cycle the grant is shown. A master that is not granted keeps its request stable until it is granted.

Each slave arbiter holds a pointer to the master it served last and a credit counter. A master with weight w at a slave may take up to w back-to-back grants there while others wait. After that, priority passes to the next requesting master in cyclic index order. A weight of zero means the master has no path to that slave, and its requests there are ignored. The weights are set per slave and per master by a parameter. With the default parameters there are 3 masters and 4 slaves, and the weight table is:

| Slave | Master 0 | Master 1 | Master 2 |
|-------|----------|----------|----------|
| 0     | 1        | 0        | 0        |
| 1     | 0        | 1        | 0        |
| 2     | 0        | 2        | 1        |
| 3     | 0        | 0        | 1        |

Top module: `wrr_xbar_arb`

## Requirements
- R1: After reset, and in any cycle with no valid request, `mst_grant` is 0, `slv_busy` is 0 and every `slv_sel` field is 0.
- R2: A slave grants at most one master per cycle. When `slv_busy[s]` is 1, the master in `slv_sel` field s (bits 2s+1:2s) has a valid request that targets slave s. The number of set bits in `mst_grant` equals the number of set bits in `slv_busy`. The `slv_sel` field of an idle slave reads 0.
- R3: Masters whose requests target different slaves, each with a nonzero weight there, are all granted in the same cycle.
- R4: A request to a slave at which the master's weight is 0 is never granted and does not make that slave busy.
- R5: From reset, when several masters contend for one slave, the lowest-numbered requesting master is granted first.
- R6: A master with weight w at a slave receives up to w consecutive grants there while another master keeps requesting it. At default weights, master 1 and master 2 contending continuously at slave 2 are granted in the order 1, 1, 2, 1.
- R7: When the current holder's credits run out, or its request goes away, the grant passes to the next requesting master in cyclic index order after the holder, wrapping from the highest index to 0.
- R8: A cycle in which a slave grants nobody clears that slave's remaining credits. If master 1 gets one grant at slave 2, slave 2 then sees one cycle with no request, and masters 1 and 2 then both request it, master 2 is granted.
- R9: The access pattern below completes in at most 4 cycles, and every access in it is granted. Master 0 reads slave 0 twice. Master 1 reads slave 1, then slave 2, then slave 1. Master 2 reads slave 3, then slave 2. In the first cycle, all three masters are granted.
- R10: A grant appears combinationally in the same cycle as the request it serves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | N_MST | Per-master request valid bit |
| req_slave | input | N_MST*SIDX_W | Per-master target slave index; field m is bits m*SIDX_W +: SIDX_W |
| mst_grant | output | N_MST | Per-master grant; a set bit completes that master's read in this cycle |
| slv_busy | output | N_SLV | Per-slave flag: the slave serves a master in this cycle |
| slv_sel | output | N_SLV*MIDX_W | Per-slave index of the master being served; 0 when the slave is idle |

## Verification
Two kinds of event can fall in the same cycle: parallel grants at different slaves, and a contention decision (a credit hold or a rotation) at a shared slave. The replayed access pattern provokes this. In its second cycle, master 0 is re-granted alone at slave 0 while masters 1 and 2 collide at slave 2. The scoreboard judges each cycle against a hand-derived vector that holds every grant, busy flag and selected index together, so a wrong choice at one slave cannot hide behind a correct one at another. The closed-loop replay then counts the cycles the whole pattern takes and confirms that every access was served.

// File: rtl/wrr_pkg.sv
package wrr_pkg;

   // cyclic successor of an index within 0 .. n-1
   function automatic int next_idx(input int cur, input int n);
      return (cur >= n - 1) ? 0 : cur + 1;
   endfunction

   // bit offset of the weight field of master m at slave s
   function automatic int wgt_ofs(input int s, input int m, input int n_mst, input int w_w);
      return (s * n_mst + m) * w_w;
   endfunction

endpackage

// File: rtl/wrr_req_decode.sv
module wrr_req_decode #(
   parameter int N_MST = 3,
   parameter int N_SLV = 4,
   parameter int WGT_W = 2,
   parameter logic [N_SLV*N_MST*WGT_W-1:0] WEIGHTS = '0,
   localparam int SIDX_W = $clog2(N_SLV)
) (
   input  logic [N_MST-1:0]        req_valid,
   input  logic [N_MST*SIDX_W-1:0] req_slave,
   output logic [N_SLV*N_MST-1:0]  elig
);

   for (genvar s = 0; s < N_SLV; s++) begin : g_slv
      for (genvar m = 0; m < N_MST; m++) begin : g_mst
         localparam int OFS = wrr_pkg::wgt_ofs(s, m, N_MST, WGT_W);
         localparam bit HAS_PATH = (WEIGHTS[OFS +: WGT_W] != '0);
         if (HAS_PATH) begin : g_path
            assign elig[s*N_MST+m] = req_valid[m] &&
                                     (req_slave[m*SIDX_W +: SIDX_W] == SIDX_W'(s));
         end else begin : g_nopath
            assign elig[s*N_MST+m] = 1'b0;
         end
      end
   end

endmodule

// File: rtl/wrr_slave_arb.sv
module wrr_slave_arb #(
   parameter int N_MST = 3,
   parameter int WGT_W = 2,
   localparam int MIDX_W = $clog2(N_MST)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_MST-1:0]       elig,
   input  logic [N_MST*WGT_W-1:0] wgt,
   output logic [N_MST-1:0]       gnt,
   output logic                   busy,
   output logic [MIDX_W-1:0]      sel
);

   logic [MIDX_W-1:0] hold_q, hold_d, pick, idx;
   logic [WGT_W-1:0]  cnt_q, cnt_d, wpick;
   logic              take, reload;

   always_comb begin
      take   = 1'b0;
      reload = 1'b0;
      pick   = hold_q;
      idx    = hold_q;
      if (elig[hold_q] && cnt_q != '0) begin
         take = 1'b1;
      end else begin
         for (int k = 0; k < N_MST; k++) begin
            idx = MIDX_W'(wrr_pkg::next_idx(int'(idx), N_MST));
            if (!take && elig[idx]) begin
               take   = 1'b1;
               reload = 1'b1;
               pick   = idx;
            end
         end
      end
      wpick = wgt[int'(pick)*WGT_W +: WGT_W];
      if (!take)       cnt_d = '0;
      else if (reload) cnt_d = wpick - 1'b1;
      else             cnt_d = cnt_q - 1'b1;
      hold_d = take ? pick : hold_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= MIDX_W'(N_MST - 1);
         cnt_q  <= '0;
      end else begin
         hold_q <= hold_d;
         cnt_q  <= cnt_d;
      end
   end

   always_comb begin
      gnt = '0;
      if (take) gnt[pick] = 1'b1;
   end

   assign busy = take;
   assign sel  = take ? pick : '0;

endmodule

// File: rtl/wrr_grant_merge.sv
module wrr_grant_merge #(
   parameter int N_MST = 3,
   parameter int N_SLV = 4
) (
   input  logic [N_SLV*N_MST-1:0] gnt_mat,
   output logic [N_MST-1:0]       mst_grant
);

   for (genvar m = 0; m < N_MST; m++) begin : g_mst
      always_comb begin
         mst_grant[m] = 1'b0;
         for (int s = 0; s < N_SLV; s++) mst_grant[m] = mst_grant[m] | gnt_mat[s*N_MST+m];
      end
   end

endmodule

// File: rtl/wrr_xbar_arb.sv
module wrr_xbar_arb #(
   parameter int N_MST = 3,
   parameter int N_SLV = 4,
   parameter int WGT_W = 2,
   parameter logic [N_SLV*N_MST*WGT_W-1:0] WEIGHTS = 24'h418101,
   localparam int SIDX_W = $clog2(N_SLV),
   localparam int MIDX_W = $clog2(N_MST)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_MST-1:0]        req_valid,
   input  logic [N_MST*SIDX_W-1:0] req_slave,
   output logic [N_MST-1:0]        mst_grant,
   output logic [N_SLV-1:0]        slv_busy,
   output logic [N_SLV*MIDX_W-1:0] slv_sel
);

   if (N_MST < 2) begin : g_bad_mst
      $error("wrr_xbar_arb: N_MST must be at least 2");
   end
   if (N_SLV < 2) begin : g_bad_slv
      $error("wrr_xbar_arb: N_SLV must be at least 2");
   end
   if (WGT_W < 1) begin : g_bad_wgt
      $error("wrr_xbar_arb: WGT_W must be at least 1");
   end

   logic [N_SLV*N_MST-1:0] elig;
   logic [N_SLV*N_MST-1:0] gnt_mat;

   wrr_req_decode #(
      .N_MST(N_MST), .N_SLV(N_SLV), .WGT_W(WGT_W), .WEIGHTS(WEIGHTS)
   ) u_dec (
      .req_valid (req_valid),
      .req_slave (req_slave),
      .elig      (elig)
   );

   for (genvar s = 0; s < N_SLV; s++) begin : g_arb
      wrr_slave_arb #(.N_MST(N_MST), .WGT_W(WGT_W)) u_arb (
         .clk   (clk),
         .rst_n (rst_n),
         .elig  (elig[s*N_MST +: N_MST]),
         .wgt   (WEIGHTS[s*N_MST*WGT_W +: N_MST*WGT_W]),
         .gnt   (gnt_mat[s*N_MST +: N_MST]),
         .busy  (slv_busy[s]),
         .sel   (slv_sel[s*MIDX_W +: MIDX_W])
      );
   end

   wrr_grant_merge #(.N_MST(N_MST), .N_SLV(N_SLV)) u_merge (
      .gnt_mat   (gnt_mat),
      .mst_grant (mst_grant)
   );

endmodule

// File: rtl/wrr_xbar_arb_chk.sv
module wrr_xbar_arb_chk #(
   parameter int N_MST = 3,
   parameter int N_SLV = 4,
   parameter int WGT_W = 2,
   parameter logic [N_SLV*N_MST*WGT_W-1:0] WEIGHTS = '0,
   localparam int SIDX_W = $clog2(N_SLV),
   localparam int MIDX_W = $clog2(N_MST)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [N_MST-1:0]        req_valid,
   input logic [N_MST*SIDX_W-1:0] req_slave,
   input logic [N_MST-1:0]        mst_grant,
   input logic [N_SLV-1:0]        slv_busy,
   input logic [N_SLV*MIDX_W-1:0] slv_sel
);

   function automatic bit has_path(input int s, input int m);
      if (s >= N_SLV) return 1'b0;
      return WEIGHTS[wrr_pkg::wgt_ofs(s, m, N_MST, WGT_W) +: WGT_W] != '0;
   endfunction

   logic [N_MST-1:0] lone;
   always_comb begin
      for (int m = 0; m < N_MST; m++) begin
         lone[m] = req_valid[m] && has_path(int'(req_slave[m*SIDX_W +: SIDX_W]), m);
         for (int o = 0; o < N_MST; o++) begin
            if (o != m && req_valid[o] &&
                req_slave[o*SIDX_W +: SIDX_W] == req_slave[m*SIDX_W +: SIDX_W] &&
                has_path(int'(req_slave[o*SIDX_W +: SIDX_W]), o))
               lone[m] = 1'b0;
         end
      end
   end

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid == '0) |-> (slv_busy == '0 && mst_grant == '0 && slv_sel == '0));

   p_count_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mst_grant) == $countones(slv_busy));

   for (genvar s = 0; s < N_SLV; s++) begin : g_slv
      logic [MIDX_W-1:0] who;
      assign who = slv_sel[s*MIDX_W +: MIDX_W];

      p_sel_targets_r2: assert property (@(posedge clk) disable iff (!rst_n)
         slv_busy[s] |-> (req_valid[who] && mst_grant[who] &&
                          req_slave[int'(who)*SIDX_W +: SIDX_W] == SIDX_W'(s)));

      p_path_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
         slv_busy[s] |-> has_path(s, int'(who)));
   end

   for (genvar m = 0; m < N_MST; m++) begin : g_mst
      p_lone_served_r3: assert property (@(posedge clk) disable iff (!rst_n)
         lone[m] |-> mst_grant[m]);
   end

endmodule

bind wrr_xbar_arb wrr_xbar_arb_chk #(
   .N_MST(N_MST), .N_SLV(N_SLV), .WGT_W(WGT_W), .WEIGHTS(WEIGHTS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_slave (req_slave),
   .mst_grant (mst_grant),
   .slv_busy  (slv_busy),
   .slv_sel   (slv_sel)
);

// File: tb/wrr_xbar_arb_test.sv
module wrr_xbar_arb_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] req_valid = '0;
   logic [5:0] req_slave = '0;
   logic [2:0] mst_grant;
   logic [3:0] slv_busy;
   logic [7:0] slv_sel;

   always #5 clk = ~clk;

   wrr_xbar_arb uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_slave(req_slave),
      .mst_grant(mst_grant), .slv_busy(slv_busy), .slv_sel(slv_sel)
   );

   typedef struct {
      logic [2:0] g;
      logic [3:0] b;
      logic [7:0] s;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   ended = 0;

   function automatic logic [5:0] pk(input int t0, input int t1, input int t2);
      return {2'(t2), 2'(t1), 2'(t0)};
   endfunction

   task automatic drive(input logic [2:0] v, input int t0, input int t1, input int t2,
                        input logic [2:0] eg, input logic [3:0] eb, input logic [7:0] es,
                        input string tag);
      exp_t e;
      @(posedge clk);
      #1;
      req_valid = v;
      req_slave = pk(t0, t1, t2);
      e.g = eg; e.b = eb; e.s = es; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   // monitor: pops one expected vector per cycle and compares
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_cmp++;
         if (mst_grant !== e.g || slv_busy !== e.b || slv_sel !== e.s) begin
            n_bad++;
            $display("FAIL %s actual=g%b/b%b/s%h expected=g%b/b%b/s%h",
                     e.tag, mst_grant, slv_busy, slv_sel, e.g, e.b, e.s);
         end
      end
   end

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   // closed-loop replay of the access pattern
   int tgt[3][3] = '{'{0, 0, 0}, '{1, 2, 1}, '{3, 2, 0}};
   int len[3]    = '{2, 3, 2};

   initial begin
      int pos[3];
      int cyc;
      bit all_done;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // sel field s sits at bits 2s+1:2s
      drive(3'b000, 0, 0, 0, 3'b000, 4'b0000, 8'h00, "R1 idle after reset");
      drive(3'b001, 2, 0, 0, 3'b000, 4'b0000, 8'h00, "R4 zero-weight path ignored");
      drive(3'b111, 0, 1, 3, 3'b111, 4'b1011, 8'h84, "R3 parallel grants");
      drive(3'b110, 0, 2, 2, 3'b010, 4'b0100, 8'h10, "R5 lowest first from reset");
      drive(3'b110, 0, 2, 2, 3'b010, 4'b0100, 8'h10, "R6 weight 2 second grant");
      drive(3'b110, 0, 2, 2, 3'b100, 4'b0100, 8'h20, "R7 rotate to next");
      drive(3'b110, 0, 2, 2, 3'b010, 4'b0100, 8'h10, "R6 R7 wrap back to master 1");
      drive(3'b000, 0, 0, 0, 3'b000, 4'b0000, 8'h00, "R1 idle cycle");
      drive(3'b110, 0, 2, 2, 3'b100, 4'b0100, 8'h20, "R8 credits forfeited on idle");
      drive(3'b111, 0, 3, 3, 3'b101, 4'b1001, 8'h80, "R2 R4 one grant per slave");
      drive(3'b000, 0, 0, 0, 3'b000, 4'b0000, 8'h00, "R10 grant drops with request");
      @(posedge clk);
      @(posedge clk);

      // fresh reset before replay
      #1 rst_n = 1'b0;
      req_valid = '0;
      @(posedge clk);
      #1 rst_n = 1'b1;

      pos = '{0, 0, 0};
      cyc = 0;
      all_done = 0;
      while (!all_done && cyc < 8) begin
         @(posedge clk);
         #1;
         for (int m = 0; m < 3; m++) begin
            req_valid[m] = (pos[m] < len[m]);
            req_slave[m*2 +: 2] = (pos[m] < len[m]) ? 2'(tgt[m][pos[m]]) : 2'd0;
         end
         cyc++;
         @(negedge clk);
         check($countones(mst_grant) == $countones(slv_busy), "R2 replay grant count",
               $countones(mst_grant), $countones(slv_busy));
         if (cyc == 1)
            check(mst_grant == 3'b111, "R9 first cycle all served", mst_grant, 7);
         for (int m = 0; m < 3; m++)
            if (mst_grant[m]) pos[m]++;
         all_done = (pos[0] >= len[0]) && (pos[1] >= len[1]) && (pos[2] >= len[2]);
      end
      check(all_done, "R9 every access served", all_done, 1);
      check(cyc <= 4, "R9 cycle budget", cyc, 4);
      @(posedge clk);
      #1 req_valid = '0;
      @(negedge clk);
      check(mst_grant == 3'b000 && slv_busy == 4'b0000, "R1 quiet after replay",
            {slv_busy, mst_grant}, 0);
      finish_run();
   end

endmodule